// File: doc/BRIEF.md
# Cascaded Boxcar Bartlett Filter

This block smooths a stream of signed 14-bit sensor samples with a low-pass filter built from two identical moving-average stages placed back to back. Each stage averages the most recent 2^M samples it has seen, so the chain as a whole applies a triangular (Bartlett) weighting to the input. A 3-bit exponent picks M. A 3-bit range code can raise M to a minimum value, so that a more sensitive measurement range is never filtered more lightly than its resolution allows.

Samples enter and leave on valid/ready streams. An input sample is taken on a clock edge where `in_valid` and `in_ready` are both high. Its filtered result is shown on the output from the next cycle on and stays there until `out_ready` takes it. A single output register holds one result. `in_ready` is high whenever that register is empty or is being emptied in the same cycle, so a stall at the output goes straight back to the input without any extra buffering. The configuration pins are plain levels. Any change on them throws away all filter history.

Top module: `bartlett_filter`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high, and the filter history is empty (all earlier samples count as zero).
- R2: When the effective exponent is 0, each output equals its input sample unchanged.
- R3: Each stage outputs floor(S / 2^M), where S is the sum of the last 2^M samples that stage received and any slot not yet filled since the last clear counts as zero. The second stage takes the first stage's outputs as its input.
- R4: With M = 2, a single input of 4096 followed by zeros gives the outputs 256, 512, 768, 1024, 768, 512, 256, 0.
- R5: Range code 3'b010 sets the effective exponent to max(`cfg_exp`, 2). An exponent above that floor is used as given.
- R6: Range code 3'b001 sets the effective exponent to max(`cfg_exp`, 4). Code 3'b100, and any code other than 3'b010 and 3'b001, places no floor.
- R7: A change of `cfg_exp` or `cfg_range` between two clock edges clears the history and the sums of both stages.
- R8: Every accepted input gives exactly one output, in order, and `out_valid` goes high in the cycle right after the accepting edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and `in_ready` is low. While `out_valid` is low, `in_ready` is high.
- R10: Full-scale constant inputs (-8192 or 8191) at M = 7 settle to exactly that value, with no wrap-around in the sums.
- R11: When the configuration changes in the same cycle as a sample is accepted, that sample is filtered with the new configuration as the first sample of a cleared history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_exp | input | 3 | Requested exponent M; each stage has 2^M taps |
| cfg_range | input | 3 | Range code; 3'b010 sets a floor of M = 2, 3'b001 sets a floor of M = 4 |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Filter can take an input sample this cycle |
| in_data | input | 14 | Input sample, two's complement |
| out_valid | output | 1 | Filtered sample is present |
| out_ready | input | 1 | Downstream takes the filtered sample |
| out_data | output | 14 | Filtered sample, two's complement |

## Verification
A configuration change and an accepted sample can land on the same clock edge. In that case the clear of both stages and the update of the running sums happen together, and the sample must become the first entry of a fresh history under the new exponent. The bench causes this by changing the exponent or range in the same cycle in which it presents a sample. It also does the same thing while the output is stalled, so the sample is accepted some cycles after the change. The scoreboard model clears its own history at every configuration change, and each output is compared with that model, so a design that drops the clear or applies it one sample late is caught. Random output stalls run at the same time to check the hold and back-pressure rules.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int EXP_W   = 3;
  localparam int RANGE_W = 3;

  typedef enum logic [RANGE_W-1:0] {
    RNG_WIDE = 3'b100,
    RNG_MID  = 3'b010,
    RNG_FINE = 3'b001
  } range_e;

  // minimum exponent demanded by a range code
  function automatic logic [EXP_W-1:0] exp_floor(input logic [RANGE_W-1:0] rng);
    case (rng)
      RNG_MID:  return EXP_W'(2);
      RNG_FINE: return EXP_W'(4);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/bf_cfg_ctrl.sv
module bf_cfg_ctrl
  import bf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EXP_W-1:0]   cfg_exp,
  input  logic [RANGE_W-1:0] cfg_range,
  output logic [EXP_W-1:0]   eff_exp,
  output logic               restart
);
  logic [EXP_W-1:0]   exp_q;
  logic [RANGE_W-1:0] range_q;
  logic [EXP_W-1:0]   floor_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q   <= '0;
      range_q <= RNG_WIDE;
    end else begin
      exp_q   <= cfg_exp;
      range_q <= cfg_range;
    end
  end

  always_comb begin
    floor_val = exp_floor(cfg_range);
    eff_exp   = (cfg_exp < floor_val) ? floor_val : cfg_exp;
    restart   = (cfg_exp != exp_q) || (cfg_range != range_q);
  end
endmodule

// File: rtl/bf_boxcar.sv
module bf_boxcar
  import bf_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                advance,
  input  logic [EXP_W-1:0]    m,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] dout
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int DEPTH   = 1 << MAX_EXP;
  localparam int PW      = MAX_EXP;
  localparam int SUM_W   = SAMPLE_W + MAX_EXP;

  logic [SAMPLE_W-1:0]     mem [DEPTH];
  logic [PW-1:0]           wr_ptr;
  logic                    full;
  logic signed [SUM_W-1:0] acc;

  logic [PW-1:0]           base_ptr;
  logic                    base_full;
  logic signed [SUM_W-1:0] base_acc;
  logic [SAMPLE_W-1:0]     old_val;
  logic signed [SUM_W-1:0] din_ext;
  logic signed [SUM_W-1:0] old_ext;
  logic signed [SUM_W-1:0] acc_next;
  logic [PW-1:0]           mask;
  logic                    wrap;
  logic [PW-1:0]           ptr_next;

  always_comb begin
    base_ptr  = restart ? '0 : wr_ptr;
    base_full = restart ? 1'b0 : full;
    base_acc  = restart ? '0 : acc;
    old_val   = base_full ? mem[base_ptr] : '0;
    din_ext   = $signed({{MAX_EXP{din[SAMPLE_W-1]}}, din});
    old_ext   = $signed({{MAX_EXP{old_val[SAMPLE_W-1]}}, old_val});
    acc_next  = base_acc + din_ext - old_ext;
    mask      = ~({PW{1'b1}} << m);
    wrap      = (base_ptr == mask);
    ptr_next  = wrap ? '0 : base_ptr + PW'(1);
    dout      = SAMPLE_W'(acc_next >>> m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      full   <= 1'b0;
      acc    <= '0;
    end else if (advance) begin
      wr_ptr <= ptr_next;
      full   <= base_full | wrap;
      acc    <= acc_next;
    end else if (restart) begin
      wr_ptr <= '0;
      full   <= 1'b0;
      acc    <= '0;
    end
  end

  // history slots, only read once written since the last clear
  always_ff @(posedge clk) begin
    if (advance) mem[base_ptr] <= din;
  end
endmodule

// File: rtl/bartlett_filter.sv
module bartlett_filter
  import bf_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int NUM_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_exp,
  input  logic [2:0]          cfg_range,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data
);
  logic [EXP_W-1:0]    eff_exp;
  logic                restart;
  logic                accept;
  logic [SAMPLE_W-1:0] chain [NUM_STAGES+1];

  bf_cfg_ctrl u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_exp   (cfg_exp),
    .cfg_range (cfg_range),
    .eff_exp   (eff_exp),
    .restart   (restart)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign chain[0] = in_data;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    bf_boxcar #(.SAMPLE_W(SAMPLE_W)) u_box (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .advance (accept),
      .m       (eff_exp),
      .din     (chain[s]),
      .dout    (chain[s+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= chain[NUM_STAGES];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bartlett_filter_chk.sv
module bartlett_filter_chk #(
  parameter int SAMPLE_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          cfg_exp,
  input logic [2:0]          cfg_range,
  input logic                in_valid,
  input logic                in_ready,
  input logic [SAMPLE_W-1:0] in_data,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_data
);
  assert_out_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_ready_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_exp == 3'd0 && cfg_range != 3'b010 && cfg_range != 3'b001)
      |=> (out_data == $past(in_data)));
endmodule

bind bartlett_filter bartlett_filter_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_exp   (cfg_exp),
  .cfg_range (cfg_range),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/bartlett_filter_bench.sv
`timescale 1ns/1ps
module bartlett_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_exp = 3'd0;
  logic [2:0]  cfg_range = 3'b100;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [13:0] out_data;

  always #4 clk = ~clk;

  bartlett_filter u_bartlett_filter (
    .clk(clk), .rst_n(rst_n), .cfg_exp(cfg_exp), .cfg_range(cfg_range),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct {
    int    val;
    int    cyc;
    string tag;
  } item_t;

  item_t sb[$];
  int    n_checks = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    bp_on = 1'b0;
  bit    done = 1'b0;
  int    m_eff = 0;
  int    h1[$];
  int    h2[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int range_floor(input int r);
    if (r == 2) return 2;
    if (r == 1) return 4;
    return 0;
  endfunction

  function automatic int model_step(input int x);
    int n;
    longint s;
    int a1;
    n = 1 << m_eff;
    h1.push_back(x);
    if (h1.size() > n) void'(h1.pop_front());
    s = 0;
    foreach (h1[i]) s += h1[i];
    a1 = int'(s >>> m_eff);
    h2.push_back(a1);
    if (h2.size() > n) void'(h2.pop_front());
    s = 0;
    foreach (h2[i]) s += h2[i];
    return int'(s >>> m_eff);
  endfunction

  // caller is at a falling edge
  task automatic set_cfg(input int e, input int r);
    if (e != int'(cfg_exp) || r != int'(cfg_range)) begin
      h1.delete();
      h2.delete();
    end
    cfg_exp   = 3'(e);
    cfg_range = 3'(r);
    m_eff = (e < range_floor(r)) ? range_floor(r) : e;
  endtask

  task automatic send_core(input int x, input bit lit, input int litv, input string tag);
    item_t it;
    int mv;
    in_valid = 1'b1;
    in_data  = 14'(x);
    while (!in_ready) @(negedge clk);
    mv = model_step(x);
    it.val = lit ? litv : mv;
    it.cyc = cyc + 1;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(input int x, input string tag);
    send_core(x, 1'b0, 0, tag);
  endtask

  task automatic drain();
    int guard = 0;
    while (sb.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // output acceptance changes just after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor and scoreboard
  initial begin
    bit seen = 1'b0;
    bit stall_prev = 1'b0;
    logic [13:0] held = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stall_prev) begin
          check(out_valid == 1'b1, "R9 valid held under stall", int'(out_valid), 1);
          check(out_data == held, "R9 data held under stall", int'(out_data), int'(held));
        end
        if (out_valid && !out_ready)
          check(in_ready == 1'b0, "R9 in_ready low under stall", int'(in_ready), 0);
        if (!out_valid)
          check(in_ready == 1'b1, "R9 in_ready high when empty", int'(in_ready), 1);
        if (out_valid) begin
          if (sb.size() == 0) begin
            check(1'b0, "R8 unexpected output", int'($signed(out_data)), 0);
          end else begin
            if (!seen) begin
              check(cyc == sb[0].cyc, "R8 latency", cyc, sb[0].cyc);
              seen = 1'b1;
            end
            if (out_ready) begin
              check(int'($signed(out_data)) == sb[0].val, sb[0].tag,
                    int'($signed(out_data)), sb[0].val);
              void'(sb.pop_front());
              seen = 1'b0;
            end
          end
        end
        stall_prev = out_valid && !out_ready;
        held = out_data;
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int imp[8] = '{256, 512, 768, 1024, 768, 512, 256, 0};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty history shows as a zero-padded ramp
    set_cfg(1, 4);
    send(400, "R1 first output from empty history");
    send(400, "R1 second output");
    drain();

    // R2 pass-through
    set_cfg(0, 4);
    foreach (imp[i]) send(imp[i] - 700, "R2 pass-through");
    send(-8192, "R2 pass-through min");
    send(8191, "R2 pass-through max");
    drain();

    // R4 triangular impulse response
    set_cfg(2, 4);
    send_core(4096, 1'b1, imp[0], "R4 impulse tap 0");
    for (int i = 1; i < 8; i++) send_core(0, 1'b1, imp[i], "R4 impulse tap");
    drain();

    // R3 random data under back-pressure
    bp_on = 1'b1;
    set_cfg(3, 4);
    for (int i = 0; i < 40; i++) send(int'($urandom % 16384) - 8192, "R3 averaging");
    drain();

    // R5 floor for mid range
    set_cfg(0, 2);
    send(4096, "R5 floor M>=2");
    for (int i = 0; i < 8; i++) send(0, "R5 floor M>=2");
    set_cfg(5, 2);
    for (int i = 0; i < 20; i++) send(i * 37 - 300, "R5 exponent above floor");
    drain();

    // R6 floor for fine range, and other codes
    set_cfg(1, 1);
    for (int i = 0; i < 40; i++) send((i % 5) * 900 - 1500, "R6 floor M>=4");
    set_cfg(0, 7);
    for (int i = 0; i < 6; i++) send(i * 1111 - 3000, "R6 no floor for other code");
    drain();

    // R7 clearing on a change
    bp_on = 1'b0;
    set_cfg(3, 4);
    for (int i = 0; i < 12; i++) send(1000, "R7 fill");
    set_cfg(2, 4);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) send(-600, "R7 cleared after exponent change");
    set_cfg(2, 2);
    @(negedge clk);
    send(2000, "R7 cleared after range change");
    drain();

    // R11 change in the same cycle as a sample, with and without stalls
    set_cfg(2, 4);
    for (int i = 0; i < 6; i++) send(3000, "R11 fill");
    set_cfg(3, 4);
    send(-2000, "R11 same-cycle change");
    send(-2000, "R11 next sample");
    bp_on = 1'b1;
    for (int k = 0; k < 6; k++) begin
      set_cfg(k % 2 == 0 ? 1 : 4, 4);
      send(1500 * k - 4000, "R11 change with stalls");
      send(700, "R11 change with stalls");
    end
    drain();

    // R10 full scale
    bp_on = 1'b0;
    set_cfg(7, 4);
    for (int i = 0; i < 260; i++) send(-8192, "R10 negative full scale");
    for (int i = 0; i < 260; i++) send(8191, "R10 positive full scale");
    drain();
    check(int'($signed(out_data)) == 8191, "R10 settled at max", int'($signed(out_data)), 8191);
    check(sb.size() == 0, "R8 all outputs seen", sb.size(), 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule